// File: doc/BRIEF.md
# Windowed Deadman Timer with Two-Key Restart

This block is a windowed deadman timer on a 32-bit register bus. Once software sets the enable bit, a counter advances by one on every clock. Software must restart the counter before it reaches a programmed period. A restart takes two steps. First an arming key goes into one register. Then a restart key goes into a second register, and that second write counts only while the clear window is open. The window is the last stretch of the period, and its length comes from a window-interval register.

A wrong key, a restart write without arming, or a restart write outside the window is a violation. So is letting the counter reach the period. Each kind of violation sets its own sticky status flag and a shared event flag. Every violation also produces a one-cycle reset-request pulse and sets a sticky reset-cause flag, which the system reset logic can sample. Every writable register has a plain write address, a bit-clear alias and a bit-set alias. Software can therefore change single bits without reading first. In the clock cycle right after the timer is switched off, the bus is locked out.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, rdata_o reads 0 for the control, status, counter and cause registers, the period reads RST_PERIOD and the window interval reads RST_WINDOW; rst_req_o and rst_cause_o are 0.
- R2: addr_i[7:4] selects the register: 0 control, 1 arm key, 2 restart key, 3 status, 4 counter, 5 cause, 6 period, 7 window interval. addr_i[3:2] selects the write form: 0 plain write, 1 clear the bits set in wdata_i, 2 set the bits set in wdata_i, 3 no effect. Writes to the counter and to unused selects have no effect. Reads depend only on addr_i[7:4].
- R3: Control bit 15 is the enable bit. While it is set, the counter rises by one per clock. While it is clear, the counter reads 0.
- R4: Status bit 0 (window open) is 1 exactly when the timer is enabled, the counter is at least the threshold and the counter is below the period. The threshold is period minus window interval, or 0 when the window interval is not below the period.
- R5: While enabled, a plain write with wdata_i[15:8]=0x40 to the arm register arms the restart. A following plain write with wdata_i[7:0]=0x08 to the restart register while the window is open sets the counter to 0 at the next edge and disarms.
- R6: While enabled, a plain write to the arm register with any other value in wdata_i[15:8] sets status bit 7 and bit 5, pulses rst_req_o and disarms.
- R7: While enabled, a plain write to the restart register with a wrong key, without arming, or with the window closed sets status bit 6 and bit 5, pulses rst_req_o and disarms.
- R8: While enabled, when the counter is at or above the period, the counter returns to 0, status bit 5 is set and rst_req_o is high for the next cycle.
- R9: Every rst_req_o pulse sets rst_cause_o and cause-register bit 5 in the same cycle. They clear only on a clear-form write to the cause register with wdata_i[5]=1. If that clear meets a new pulse, the set wins.
- R10: Status bits 7, 6 and 5 are sticky. Each one clears only on a clear-form write to the status register with the matching wdata_i bit set. A new violation in the same cycle wins over the clear.
- R11: In the cycle right after the enable bit changes from 1 to 0, every write is ignored and rdata_o reads 0.
- R12: Key writes have no effect while the timer is disabled. Clear-form and set-form writes to the arm or restart register are never key writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register select and write form |
| we_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected register |
| rst_req_o | output | 1 | One-cycle reset request |
| rst_cause_o | output | 1 | Sticky reset-cause flag |

## Verification
A wrong counter value shows on the counter read at the very next sample. It also moves the window edge on status bit 0 and the timeout pulse by the same number of cycles. A lost or stuck arming state only shows at the next restart write. That write either restarts the counter or raises bit 6, rst_req_o and rst_cause_o one cycle later. A broken bus lockout or write form shows as a wrong read-back of the period or enable bit on the next cycle. A sticky flag that clears itself shows up the next time status is read.

// File: rtl/dmtk_pkg.sv
`timescale 1ns/1ps
package dmtk_pkg;

  localparam int unsigned BUS_W   = 32;
  localparam int unsigned ADR_W   = 8;

  typedef enum logic [3:0] {
    SEL_CTRL   = 4'd0,
    SEL_ARM    = 4'd1,
    SEL_KICK   = 4'd2,
    SEL_STAT   = 4'd3,
    SEL_CNT    = 4'd4,
    SEL_CAUSE  = 4'd5,
    SEL_PERIOD = 4'd6,
    SEL_WINDOW = 4'd7
  } dmtk_sel_e;

  typedef enum logic [1:0] {
    AL_WRITE = 2'd0,
    AL_CLR   = 2'd1,
    AL_SET   = 2'd2,
    AL_NONE  = 2'd3
  } dmtk_alias_e;

  localparam int unsigned EN_BIT    = 15;
  localparam int unsigned ST_WIN    = 0;
  localparam int unsigned ST_EVT    = 5;
  localparam int unsigned ST_BAD2   = 6;
  localparam int unsigned ST_BAD1   = 7;
  localparam int unsigned CAUSE_BIT = 5;

  localparam logic [7:0] ARM_KEY  = 8'h40;
  localparam logic [7:0] KICK_KEY = 8'h08;

  typedef struct packed {
    logic ctrl;
    logic period;
    logic window;
    logic arm;
    logic kick;
    logic stat_clr;
    logic cause_clr;
  } dmtk_wr_t;

endpackage

// File: rtl/dmtk_bus_dec.sv
`timescale 1ns/1ps
module dmtk_bus_dec
  import dmtk_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic [ADR_W-1:0] addr_i,
  input  logic             we_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             lock_i,
  output dmtk_wr_t         wr_o,
  output logic [1:0]       alias_o,
  output logic             en_bit_o,
  output logic [CNT_W-1:0] cfg_data_o,
  output logic [7:0]       arm_val_o,
  output logic [7:0]       kick_val_o,
  output logic [2:0]       flag_mask_o
);

  localparam int unsigned SEL_LSB = 4;
  localparam int unsigned AL_LSB  = 2;

  logic [3:0] sel;
  logic [1:0] al;
  logic       acc;
  logic       unused_bits;

  assign sel = addr_i[SEL_LSB +: 4];
  assign al  = addr_i[AL_LSB +: 2];
  assign acc = we_i & ~lock_i;

  always_comb begin
    wr_o           = '0;
    wr_o.ctrl      = acc && (sel == SEL_CTRL);
    wr_o.period    = acc && (sel == SEL_PERIOD);
    wr_o.window    = acc && (sel == SEL_WINDOW);
    wr_o.arm       = acc && (sel == SEL_ARM)  && (al == AL_WRITE);
    wr_o.kick      = acc && (sel == SEL_KICK) && (al == AL_WRITE);
    wr_o.stat_clr  = acc && (sel == SEL_STAT) && (al == AL_CLR);
    wr_o.cause_clr = acc && (sel == SEL_CAUSE) && (al == AL_CLR) && wdata_i[CAUSE_BIT];
  end

  assign alias_o     = al;
  assign en_bit_o    = wdata_i[EN_BIT];
  assign cfg_data_o  = wdata_i[CNT_W-1:0];
  assign arm_val_o   = wdata_i[15:8];
  assign kick_val_o  = wdata_i[7:0];
  assign flag_mask_o = {wdata_i[ST_BAD1], wdata_i[ST_BAD2], wdata_i[ST_EVT]};
  assign unused_bits = ^{addr_i[1:0], wdata_i};

endmodule

// File: rtl/dmtk_cfg_regs.sv
`timescale 1ns/1ps
module dmtk_cfg_regs
  import dmtk_pkg::*;
#(
  parameter int unsigned       CNT_W      = 32,
  parameter logic [CNT_W-1:0]  RST_PERIOD = CNT_W'(100000),
  parameter logic [CNT_W-1:0]  RST_WINDOW = CNT_W'(1000)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  dmtk_wr_t         wr_i,
  input  logic [1:0]       alias_i,
  input  logic             en_bit_i,
  input  logic [CNT_W-1:0] cfg_data_i,
  output logic             en_o,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] window_o,
  output logic             lock_o
);

  logic             en_q, en_d, en_ce;
  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W-1:0] window_q, window_d;
  logic             lock_q, lock_d;

  function automatic logic [CNT_W-1:0] merge(input logic [CNT_W-1:0] cur,
                                             input logic [CNT_W-1:0] val,
                                             input logic [1:0]       al);
    case (al)
      AL_WRITE: merge = val;
      AL_CLR:   merge = cur & ~val;
      AL_SET:   merge = cur | val;
      default:  merge = cur;
    endcase
  endfunction

  always_comb begin
    case (alias_i)
      AL_WRITE: en_d = en_bit_i;
      AL_CLR:   en_d = en_q & ~en_bit_i;
      AL_SET:   en_d = en_q | en_bit_i;
      default:  en_d = en_q;
    endcase
    if (!wr_i.ctrl) en_d = en_q;
    en_ce    = wr_i.ctrl;
    period_d = merge(period_q, cfg_data_i, alias_i);
    window_d = merge(window_q, cfg_data_i, alias_i);
    lock_d   = en_q & ~en_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      period_q <= RST_PERIOD;
      window_q <= RST_WINDOW;
      lock_q   <= 1'b0;
    end else begin
      if (en_ce)        en_q     <= en_d;
      if (wr_i.period)  period_q <= period_d;
      if (wr_i.window)  window_q <= window_d;
      lock_q <= lock_d;
    end
  end

  assign en_o     = en_q;
  assign period_o = period_q;
  assign window_o = window_q;
  assign lock_o   = lock_q;

endmodule

// File: rtl/dmtk_counter.sv
`timescale 1ns/1ps
module dmtk_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] window_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             win_o,
  output logic             tmo_o
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, thr;
  logic             cnt_ce;

  always_comb begin
    thr   = (window_i >= period_i) ? ZERO : (period_i - window_i);
    tmo_o = en_i && (cnt_q >= period_i);
    win_o = en_i && (cnt_q >= thr) && (cnt_q < period_i);
    if (!en_i)                      cnt_d = ZERO;
    else if (restart_i || tmo_o)    cnt_d = ZERO;
    else                            cnt_d = cnt_q + ONE;
    cnt_ce = en_i || (cnt_q != ZERO);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= ZERO;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/dmtk_guard.sv
`timescale 1ns/1ps
module dmtk_guard
  import dmtk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       win_i,
  input  logic       tmo_i,
  input  dmtk_wr_t   wr_i,
  input  logic [7:0] arm_val_i,
  input  logic [7:0] kick_val_i,
  input  logic [2:0] flag_mask_i,
  output logic       restart_o,
  output logic [2:0] flags_o,
  output logic       cause_o,
  output logic       req_o
);

  logic       arm_q, arm_d, arm_ce;
  logic [2:0] flg_q, flg_d, clr_m, set_m;
  logic       flg_ce;
  logic       cause_q, cause_d;
  logic       req_q;
  logic       arm_wr, kick_wr, arm_ok, kick_ok, bad1, bad2, hit;

  always_comb begin
    arm_wr  = wr_i.arm  & en_i;
    kick_wr = wr_i.kick & en_i;
    arm_ok  = arm_wr && (arm_val_i == ARM_KEY);
    kick_ok = kick_wr && (kick_val_i == KICK_KEY) && arm_q && win_i;
    bad1    = arm_wr & ~arm_ok;
    bad2    = kick_wr & ~kick_ok;
    hit     = tmo_i | bad1 | bad2;

    if (!en_i || tmo_i || bad1 || kick_wr) arm_d = 1'b0;
    else if (arm_ok)                       arm_d = 1'b1;
    else                                   arm_d = arm_q;
    arm_ce = (arm_d != arm_q);

    clr_m  = wr_i.stat_clr ? flag_mask_i : 3'b000;
    set_m  = {bad1, bad2, hit};
    flg_d  = (flg_q & ~clr_m) | set_m;
    flg_ce = wr_i.stat_clr | hit;

    cause_d = hit | (cause_q & ~wr_i.cause_clr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q   <= 1'b0;
      flg_q   <= 3'b000;
      cause_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      if (arm_ce) arm_q <= arm_d;
      if (flg_ce) flg_q <= flg_d;
      cause_q <= cause_d;
      req_q   <= hit;
    end
  end

  assign restart_o = kick_ok;
  assign flags_o   = flg_q;
  assign cause_o   = cause_q;
  assign req_o     = req_q;

endmodule

// File: rtl/wdt_keyed.sv
`timescale 1ns/1ps
module wdt_keyed
  import dmtk_pkg::*;
#(
  parameter int unsigned      CNT_W      = 32,
  parameter logic [CNT_W-1:0] RST_PERIOD = CNT_W'(100000),
  parameter logic [CNT_W-1:0] RST_WINDOW = CNT_W'(1000)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  addr_i,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        rst_req_o,
  output logic        rst_cause_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  dmtk_wr_t         wr;
  logic [1:0]       wr_alias;
  logic             en_bit;
  logic [CNT_W-1:0] cfg_data;
  logic [7:0]       arm_val, kick_val;
  logic [2:0]       flag_mask;
  logic             en_q, lock_q, win, tmo, restart;
  logic [CNT_W-1:0] period_q, window_q, cnt_q;
  logic [2:0]       flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  dmtk_bus_dec #(.CNT_W(CNT_W)) u_dec (
    .addr_i      (addr_i),
    .we_i        (we_i),
    .wdata_i     (wdata_i),
    .lock_i      (lock_q),
    .wr_o        (wr),
    .alias_o     (wr_alias),
    .en_bit_o    (en_bit),
    .cfg_data_o  (cfg_data),
    .arm_val_o   (arm_val),
    .kick_val_o  (kick_val),
    .flag_mask_o (flag_mask)
  );

  dmtk_cfg_regs #(.CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD), .RST_WINDOW(RST_WINDOW)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .wr_i       (wr),
    .alias_i    (wr_alias),
    .en_bit_i   (en_bit),
    .cfg_data_i (cfg_data),
    .en_o       (en_q),
    .period_o   (period_q),
    .window_o   (window_q),
    .lock_o     (lock_q)
  );

  dmtk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .en_i      (en_q),
    .restart_i (restart),
    .period_i  (period_q),
    .window_i  (window_q),
    .cnt_o     (cnt_q),
    .win_o     (win),
    .tmo_o     (tmo)
  );

  dmtk_guard u_grd (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_s),
    .en_i        (en_q),
    .win_i       (win),
    .tmo_i       (tmo),
    .wr_i        (wr),
    .arm_val_i   (arm_val),
    .kick_val_i  (kick_val),
    .flag_mask_i (flag_mask),
    .restart_o   (restart),
    .flags_o     (flags),
    .cause_o     (rst_cause_o),
    .req_o       (rst_req_o)
  );

  always_comb begin
    rdata_o = '0;
    if (!lock_q) begin
      case (addr_i[7:4])
        SEL_CTRL:   rdata_o[EN_BIT] = en_q;
        SEL_STAT: begin
          rdata_o[ST_WIN]  = win;
          rdata_o[ST_EVT]  = flags[0];
          rdata_o[ST_BAD2] = flags[1];
          rdata_o[ST_BAD1] = flags[2];
        end
        SEL_CNT:    rdata_o = BUS_W'(cnt_q);
        SEL_CAUSE:  rdata_o[CAUSE_BIT] = rst_cause_o;
        SEL_PERIOD: rdata_o = BUS_W'(period_q);
        SEL_WINDOW: rdata_o = BUS_W'(window_q);
        default:    rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/dmtk_checker.sv
`timescale 1ns/1ps
module dmtk_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_n_i,
  input logic             en_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] period_i,
  input logic             win_i,
  input logic             lock_i,
  input logic             req_i,
  input logic             cause_i,
  input logic [7:0]       addr_i,
  input logic             we_i,
  input logic [31:0]      wdata_i
);

  logic kick_wr_raw, cause_clr_raw;
  assign kick_wr_raw   = we_i && (addr_i[7:4] == 4'd2) && (addr_i[3:2] == 2'd0);
  assign cause_clr_raw = we_i && (addr_i[7:4] == 4'd5) && (addr_i[3:2] == 2'd1) && wdata_i[5];

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (en_i && (cnt_i < period_i) && !kick_wr_raw) |=> (cnt_i == $past(cnt_i) + CNT_W'(1))); // R3
  AST_OFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !en_i |=> (cnt_i == '0)); // R3
  AST_WIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    win_i |-> (en_i && (cnt_i < period_i))); // R4
  AST_TMO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (en_i && (cnt_i >= period_i)) |=> (cnt_i == '0)); // R8
  AST_TMO_REQ: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (en_i && (cnt_i >= period_i)) |=> req_i); // R8
  AST_REQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    req_i |-> cause_i); // R9
  AST_CAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (cause_i && !cause_clr_raw) |=> cause_i); // R9
  AST_LOCK_ONE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    lock_i |=> !lock_i); // R11

endmodule

bind wdt_keyed dmtk_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_n_i  (rst_n_s),
  .en_i     (en_q),
  .cnt_i    (cnt_q),
  .period_i (period_q),
  .win_i    (win),
  .lock_i   (lock_q),
  .req_i    (rst_req_o),
  .cause_i  (rst_cause_o),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .wdata_i  (wdata_i)
);

// File: tb/wdt_keyed_tb.sv
`timescale 1ns/1ps
module wdt_keyed_tb;

  localparam int CLK_P = 10;
  localparam logic [31:0] P_RST = 32'd100000;
  localparam logic [31:0] W_RST = 32'd1000;

  logic        clk, rst_n, we, req, cause;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string cur_req = "R1";

  logic        m_en, m_arm, m_b1, m_b2, m_ev, m_cause, m_req, m_lock;
  logic [31:0] m_cnt, m_per, m_win;

  wdt_keyed #(.CNT_W(32), .RST_PERIOD(P_RST), .RST_WINDOW(W_RST)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .rst_req_o(req), .rst_cause_o(cause));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] form(input logic [31:0] cur, input logic [31:0] d,
                                       input logic [1:0] al);
    if (al == 2'd0) return d;
    if (al == 2'd1) return cur & ~d;
    if (al == 2'd2) return cur | d;
    return cur;
  endfunction

  function automatic logic m_open();
    logic [31:0] thr;
    thr = (m_win >= m_per) ? 32'd0 : m_per - m_win;
    return m_en && (m_cnt >= thr) && (m_cnt < m_per);
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] v;
    v = 32'd0;
    if (m_lock) return v;
    case (a[7:4])
      4'd0: v[15] = m_en;
      4'd3: begin v[0] = m_open(); v[5] = m_ev; v[6] = m_b2; v[7] = m_b1; end
      4'd4: v = m_cnt;
      4'd5: v[5] = m_cause;
      4'd6: v = m_per;
      4'd7: v = m_win;
      default: v = 32'd0;
    endcase
    return v;
  endfunction

  task automatic m_step(input logic [7:0] a, input logic w, input logic [31:0] d);
    logic acc, k1, k1ok, k2, k2ok, b1, b2, tmo, hit, en_n, open;
    logic [31:0] tmp;
    acc  = w && !m_lock;
    open = m_open();
    tmo  = m_en && (m_cnt >= m_per);
    k1   = acc && m_en && (a[7:4] == 4'd1) && (a[3:2] == 2'd0);
    k2   = acc && m_en && (a[7:4] == 4'd2) && (a[3:2] == 2'd0);
    k1ok = k1 && (d[15:8] == 8'h40);
    k2ok = k2 && (d[7:0] == 8'h08) && m_arm && open;
    b1   = k1 && !k1ok;
    b2   = k2 && !k2ok;
    hit  = tmo || b1 || b2;
    en_n = m_en;
    if (acc && a[7:4] == 4'd0) begin
      tmp  = form({16'd0, m_en, 15'd0}, d, a[3:2]);
      en_n = tmp[15];
    end
    if (acc && a[7:4] == 4'd3 && a[3:2] == 2'd1) begin
      if (d[5]) m_ev = 1'b0;
      if (d[6]) m_b2 = 1'b0;
      if (d[7]) m_b1 = 1'b0;
    end
    m_ev = m_ev | hit; m_b1 = m_b1 | b1; m_b2 = m_b2 | b2;
    if (acc && a[7:4] == 4'd5 && a[3:2] == 2'd1 && d[5]) m_cause = 1'b0;
    m_cause = m_cause | hit;
    m_req   = hit;
    if (!m_en) m_cnt = 0;
    else if (k2ok || tmo) m_cnt = 0;
    else m_cnt = m_cnt + 1;
    if (!m_en || tmo || b1 || k2) m_arm = 1'b0;
    else if (k1ok) m_arm = 1'b1;
    if (acc && a[7:4] == 4'd6) m_per = form(m_per, d, a[3:2]);
    if (acc && a[7:4] == 4'd7) m_win = form(m_win, d, a[3:2]);
    m_lock = m_en && !en_n;
    m_en   = en_n;
  endtask

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = w; wdata = d;
    #1;
    check("rdata", rdata, m_read(a));
    check("rst_req", {31'd0, req}, {31'd0, m_req});
    check("rst_cause", {31'd0, cause}, {31'd0, m_cause});
    @(posedge clk);
    m_step(a, w, d);
  endtask

  task automatic rd(input logic [7:0] a, input int n);
    for (int i = 0; i < n; i++) cyc(a, 1'b0, 32'd0);
  endtask

  task automatic wait_cnt(input logic [31:0] v);
    while (m_cnt != v) cyc(8'h30, 1'b0, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired before the run completed");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = 8'h00; we = 1'b0; wdata = 32'd0;
    m_en = 0; m_arm = 0; m_b1 = 0; m_b2 = 0; m_ev = 0; m_cause = 0; m_req = 0; m_lock = 0;
    m_cnt = 0; m_per = P_RST; m_win = W_RST;

    // R1: reset values of every register
    cur_req = "R1";
    for (int s = 0; s < 8; s++) cyc(8'(s << 4), 1'b0, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int s = 0; s < 8; s++) cyc(8'(s << 4), 1'b0, 32'd0);

    // R2: plain, clear and set forms; ignored form; read-only counter
    cur_req = "R2";
    cyc(8'h60, 1'b1, 32'd20); rd(8'h60, 1);
    cyc(8'h70, 1'b1, 32'd6);  rd(8'h70, 1);
    cyc(8'h64, 1'b1, 32'd4);  rd(8'h60, 1);
    cyc(8'h68, 1'b1, 32'd4);  rd(8'h60, 1);
    cyc(8'h6C, 1'b1, 32'hFF); rd(8'h60, 1);
    cyc(8'h40, 1'b1, 32'd7);  rd(8'h40, 1);
    cyc(8'h90, 1'b1, 32'hFFFF_FFFF); rd(8'h90, 1);

    // R12: keys while disabled have no effect
    cur_req = "R12";
    cyc(8'h10, 1'b1, 32'h0000_1100); rd(8'h30, 1);
    cyc(8'h20, 1'b1, 32'h0000_0055); rd(8'h30, 1); rd(8'h50, 1);

    // R3: enable through the set form, counter advances
    cur_req = "R3";
    cyc(8'h08, 1'b1, 32'h0000_8000); rd(8'h00, 1); rd(8'h40, 5);

    // R4 / R5: window edge and a valid restart
    cur_req = "R5";
    cyc(8'h10, 1'b1, 32'h0000_4000);
    cur_req = "R4";
    wait_cnt(32'd12); rd(8'h30, 3);
    cur_req = "R5";
    wait_cnt(32'd15);
    cyc(8'h20, 1'b1, 32'h0000_0008); rd(8'h40, 3); rd(8'h30, 1);

    // R7: restart write with the window closed
    cur_req = "R7";
    cyc(8'h10, 1'b1, 32'h0000_4000);
    cyc(8'h20, 1'b1, 32'h0000_0008); rd(8'h30, 2); rd(8'h50, 1);

    // R10: per-bit clear of the sticky flags
    cur_req = "R10";
    cyc(8'h34, 1'b1, 32'h0000_0040); rd(8'h30, 1);
    cyc(8'h30, 1'b1, 32'h0000_00E0); rd(8'h30, 1);
    cyc(8'h34, 1'b1, 32'h0000_0020); rd(8'h30, 1);

    // R6: bad arming key
    cur_req = "R6";
    cyc(8'h10, 1'b1, 32'h0000_4100); rd(8'h30, 2);
    cyc(8'h34, 1'b1, 32'h0000_00E0); rd(8'h30, 1);

    // R7: restart without arming, then with a wrong key
    cur_req = "R7";
    wait_cnt(32'd16);
    cyc(8'h20, 1'b1, 32'h0000_0008); rd(8'h30, 1);
    cyc(8'h34, 1'b1, 32'h0000_00E0);
    cyc(8'h10, 1'b1, 32'h0000_4000);
    wait_cnt(32'd15);
    cyc(8'h20, 1'b1, 32'h0000_0009); rd(8'h30, 1);
    cyc(8'h34, 1'b1, 32'h0000_00E0);

    // R12: key through the set form does not arm
    cur_req = "R12";
    cyc(8'h18, 1'b1, 32'h0000_4000); rd(8'h30, 1);
    wait_cnt(32'd15);
    cyc(8'h20, 1'b1, 32'h0000_0008); rd(8'h30, 1);
    cyc(8'h34, 1'b1, 32'h0000_00E0);

    // R8: timeout pulse and wrap
    cur_req = "R8";
    wait_cnt(32'd18); rd(8'h40, 5); rd(8'h30, 2);

    // R9: cause is sticky, cleared only by its clear form
    cur_req = "R9";
    cyc(8'h50, 1'b1, 32'h0000_0000); rd(8'h50, 1);
    cyc(8'h58, 1'b1, 32'h0000_0000); rd(8'h50, 1);
    cyc(8'h54, 1'b1, 32'h0000_0020); rd(8'h50, 2);

    // R11: lockout in the cycle after the enable falls
    cur_req = "R11";
    cyc(8'h00, 1'b1, 32'h0000_0000);
    cyc(8'h60, 1'b1, 32'd5);
    rd(8'h60, 1); rd(8'h00, 1);
    cur_req = "R3";
    rd(8'h40, 3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule